// File: doc/BRIEF.md
# Network Packet to Bus Write Sink

This block sits between one output port of a mesh router and a pipelined memory bus, and acts as a bus master there. It takes single-flit packets from a valid/ready handshake and turns each one into bus write transfers. Every transfer uses an address phase followed by a data phase, and the address phase of one transfer may run alongside the data phase of the one before it.

There are two kinds of packet. A remote-write packet becomes one write into shared memory, at the address and with the size that the packet carries. A response packet carries data that a remote read or compare-and-swap has returned. It becomes two chained writes into bookkeeping memory. The first puts the returned data into the requesting core's bucket. The second sets that bucket's valid flag word, so software polling the flag knows the data has arrived.

The bookkeeping address places a fixed region base in the top bits, then the core number, the bucket number and a flag-select bit. A thin top joins a control state machine to a datapath that holds the accepted packet and builds the bus fields.

Top module: `net_write_sink`

## Requirements
- R1: While reset is asserted, the bus shows no transfer (trans = 2'b00) and the packet input is ready.
- R2: A flit is {kind[99], size[98:96], destination address[95:64], payload[63:0]}. A remote-write packet (kind = 0) produces one write transfer to the destination address, with the packet's size. Its data phase carries payload[63:32].
- R3: A response packet (kind = 1) first writes payload[63:32], as a 32-bit word (size 3'b010), to the bucket data word of the core in payload[13:10] and the bucket in payload[9:0].
- R4: The flag write for a response is issued in the same cycle as the data phase of the bucket data write. It targets the same bucket with address bit 2 set, and its data phase carries 32'h1.
- R5: While hReady is low, an active address phase keeps its address and control unchanged in the next cycle.
- R6: The packet input is ready only in the idle state, or in the cycle in which the last data beat of a sequence completes. It is never ready while an address phase is on the bus. Exactly one packet is consumed per write sequence.
- R7: When a packet is accepted as the last data beat completes, its first address phase starts in the very next cycle, with no idle cycle between.
- R8: A bookkeeping address is {15'h1004, core[3:0], bucket[9:0], flagSel, 2'b00}. Every core from 0 to 15 and every bucket from 0 to 1023 maps to its own data and flag word.
- R9: Every address phase is a write marked NONSEQ (trans = 2'b10). No other transfer type is ever driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Incoming flit is valid |
| inReady | output | 1 | Block accepts the flit at this edge |
| inFlit | input | 100 | Incoming flit |
| hAddr | output | 32 | Bus address |
| hTrans | output | 2 | Bus transfer type |
| hWrite | output | 1 | Bus write strobe |
| hSize | output | 3 | Bus transfer size |
| hWdata | output | 32 | Bus write data |
| hReady | input | 1 | Bus transfer completes this cycle |

## Verification
The bench builds the block with its default region base of 15'h1004 and a flag value of 1. With those values, every expected bookkeeping address follows from the formula in R8. Directed packets reach core 0 bucket 0 and core 15 bucket 1023, and random packets spread across the rest of the range. The bench holds hReady low about a third of the time, at random, and presents packets at random. Together these reach stalls in every state, including a stall of the overlapped data-and-flag cycle, as well as back-to-back acceptance on a completing data beat.

// File: rtl/nws_pkg.sv
package nws_pkg;
  localparam int ADDR_W   = 32;
  localparam int DATA_W   = 32;
  localparam int SIZE_W   = 3;
  localparam int PAY_W    = 64;
  localparam int CORE_W   = 4;
  localparam int BUCKET_W = 10;
  localparam int FLIT_W   = 1 + SIZE_W + ADDR_W + PAY_W;
  localparam int BASE_W   = ADDR_W - CORE_W - BUCKET_W - 3;

  typedef enum logic [1:0] {
    SEL_PKT  = 2'd0,
    SEL_BKD  = 2'd1,
    SEL_FLAG = 2'd2
  } addrSelT;

  typedef struct packed {
    logic    loadPkt;
    logic    addrPhase;
    addrSelT addrSel;
    logic    flagData;
  } ctrlT;
endpackage

// File: rtl/nws_ctrl.sv
module nws_ctrl
  import nws_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic inIsResp,
  input  logic hReady,
  output logic inReady,
  output ctrlT ctrl
);
  typedef enum logic [2:0] {
    S_IDLE, S_WADDR, S_WDATA, S_RADDR, S_RDATA_FADDR, S_FDATA
  } stateT;

  stateT state, nextState;
  logic  lastBeat;
  logic  take;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    lastBeat  = ((state == S_WDATA) || (state == S_FDATA)) && hReady;
    inReady   = (state == S_IDLE) || lastBeat;
    take      = inReady && inValid;
    nextState = state;
    ctrl      = '0;
    ctrl.addrSel = SEL_PKT;
    case (state)
      S_WADDR: begin
        ctrl.addrPhase = 1'b1;
        if (hReady) nextState = S_WDATA;
      end
      S_RADDR: begin
        ctrl.addrPhase = 1'b1;
        ctrl.addrSel   = SEL_BKD;
        if (hReady) nextState = S_RDATA_FADDR;
      end
      S_RDATA_FADDR: begin
        ctrl.addrPhase = 1'b1;
        ctrl.addrSel   = SEL_FLAG;
        if (hReady) nextState = S_FDATA;
      end
      S_FDATA: begin
        ctrl.flagData = 1'b1;
      end
      default: ;
    endcase
    if (take) begin
      ctrl.loadPkt = 1'b1;
      nextState    = inIsResp ? S_RADDR : S_WADDR;
    end else if (lastBeat) begin
      nextState = S_IDLE;
    end
  end
endmodule

// File: rtl/nws_datapath.sv
module nws_datapath
  import nws_pkg::*;
#(
  parameter logic [BASE_W-1:0] BK_BASE   = 15'h1004,
  parameter logic [DATA_W-1:0] FLAG_WORD = 32'h1
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlT              ctrl,
  input  logic [FLIT_W-1:0] inFlit,
  output logic              inIsResp,
  output logic [ADDR_W-1:0] hAddr,
  output logic [1:0]        hTrans,
  output logic              hWrite,
  output logic [SIZE_W-1:0] hSize,
  output logic [DATA_W-1:0] hWdata
);
  localparam logic [SIZE_W-1:0] WORD_SIZE = 3'b010;

  logic [SIZE_W-1:0]   pktSize;
  logic [ADDR_W-1:0]   pktAddr;
  logic [DATA_W-1:0]   pktData;
  logic [CORE_W-1:0]   pktCore;
  logic [BUCKET_W-1:0] pktBucket;
  logic [ADDR_W-1:0]   bkDataAddr, bkFlagAddr;

  assign inIsResp = inFlit[FLIT_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktSize   <= '0;
      pktAddr   <= '0;
      pktData   <= '0;
      pktCore   <= '0;
      pktBucket <= '0;
    end else if (ctrl.loadPkt) begin
      pktSize   <= inFlit[FLIT_W-2 -: SIZE_W];
      pktAddr   <= inFlit[PAY_W +: ADDR_W];
      pktData   <= inFlit[PAY_W-1 -: DATA_W];
      pktCore   <= inFlit[BUCKET_W +: CORE_W];
      pktBucket <= inFlit[BUCKET_W-1:0];
    end
  end

  assign bkDataAddr = {BK_BASE, pktCore, pktBucket, 1'b0, 2'b00};
  assign bkFlagAddr = {BK_BASE, pktCore, pktBucket, 1'b1, 2'b00};

  always_comb begin
    case (ctrl.addrSel)
      SEL_BKD:  hAddr = bkDataAddr;
      SEL_FLAG: hAddr = bkFlagAddr;
      default:  hAddr = pktAddr;
    endcase
    hSize  = (ctrl.addrSel == SEL_PKT) ? pktSize : WORD_SIZE;
    hTrans = ctrl.addrPhase ? 2'b10 : 2'b00;
    hWrite = ctrl.addrPhase;
    hWdata = ctrl.flagData ? FLAG_WORD : pktData;
  end
endmodule

// File: rtl/net_write_sink.sv
module net_write_sink
  import nws_pkg::*;
#(
  parameter logic [BASE_W-1:0] BK_BASE   = 15'h1004,
  parameter logic [DATA_W-1:0] FLAG_WORD = 32'h1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [FLIT_W-1:0] inFlit,
  output logic [ADDR_W-1:0] hAddr,
  output logic [1:0]        hTrans,
  output logic              hWrite,
  output logic [SIZE_W-1:0] hSize,
  output logic [DATA_W-1:0] hWdata,
  input  logic              hReady
);
  ctrlT ctrl;
  logic inIsResp;

  nws_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inIsResp(inIsResp),
    .hReady(hReady), .inReady(inReady), .ctrl(ctrl)
  );

  nws_datapath #(.BK_BASE(BK_BASE), .FLAG_WORD(FLAG_WORD)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .inFlit(inFlit), .inIsResp(inIsResp),
    .hAddr(hAddr), .hTrans(hTrans), .hWrite(hWrite), .hSize(hSize), .hWdata(hWdata)
  );
endmodule

// File: rtl/nws_checker.sv
module nws_checker
  import nws_pkg::*;
#(
  parameter logic [BASE_W-1:0] BK_BASE   = 15'h1004,
  parameter logic [DATA_W-1:0] FLAG_WORD = 32'h1
)(
  input logic              clk,
  input logic              rstN,
  input logic              inReady,
  input logic [ADDR_W-1:0] hAddr,
  input logic [1:0]        hTrans,
  input logic              hWrite,
  input logic [DATA_W-1:0] hWdata,
  input logic              hReady
);
  logic inRegion;
  assign inRegion = (hAddr[ADDR_W-1 -: BASE_W] == BK_BASE);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |-> (hTrans == 2'b00 && inReady));

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hTrans == 2'b10 && !hReady) |=> (hTrans == 2'b10 && $stable(hAddr)));

  assert_ready_bus_free_R6: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (hTrans == 2'b00));

  assert_flag_follows_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hTrans == 2'b10 && hReady && inRegion && !hAddr[2])
    |=> (hTrans == 2'b10 && hAddr[2] && hAddr[ADDR_W-1:3] == $past(hAddr[ADDR_W-1:3])));

  assert_flag_value_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hTrans == 2'b10 && hReady && inRegion && hAddr[2]) |=> (hWdata == FLAG_WORD));

  assert_nonseq_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hTrans != 2'b00) |-> (hTrans == 2'b10 && hWrite));
endmodule

bind net_write_sink nws_checker #(.BK_BASE(BK_BASE), .FLAG_WORD(FLAG_WORD)) chk_i (
  .clk(clk), .rstN(rstN), .inReady(inReady), .hAddr(hAddr), .hTrans(hTrans),
  .hWrite(hWrite), .hWdata(hWdata), .hReady(hReady)
);

// File: tb/net_write_sink_tb_top.sv
module net_write_sink_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_PKTS   = 400;
  localparam int CYC_LIMIT  = 20000;

  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic         inReady;
  logic [99:0]  inFlit;
  logic [31:0]  hAddr;
  logic [1:0]   hTrans;
  logic         hWrite;
  logic [2:0]   hSize;
  logic [31:0]  hWdata;
  logic         hReady;

  int checks = 0;
  int fails  = 0;

  // entry: [68:67] tag (2=R2, 3=R3, 1=R4), [66:35] addr, [34:32] size, [31:0] data
  logic [68:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  net_write_sink dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inFlit(inFlit),
    .hAddr(hAddr), .hTrans(hTrans), .hWrite(hWrite), .hSize(hSize),
    .hWdata(hWdata), .hReady(hReady)
  );

  function automatic string tagName(input logic [1:0] t);
    case (t)
      2'd2:    return "R2";
      2'd3:    return "R3 R8";
      default: return "R4 R8";
    endcase
  endfunction

  function automatic logic [31:0] bkAddr(input logic [3:0] core, input logic [9:0] bkt,
                                         input logic flag);
    return 32'h2008_0000 | (32'(core) << 13) | (32'(bkt) << 3) | (32'(flag) << 2);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [99:0] genPkt(input int idx);
    logic        kind;
    logic [2:0]  sz;
    logic [31:0] addr;
    logic [63:0] pay;
    kind = 1'($urandom % 2);
    sz   = 3'($urandom % 3);
    addr = $urandom & 32'h1FFF_FFFC;
    pay  = {$urandom, $urandom};
    case (idx)
      0: begin kind = 1'b1; pay[13:0] = 14'h0000; end
      1: begin kind = 1'b1; pay[13:0] = {4'hF, 10'h3FF}; end
      2: begin kind = 1'b0; sz = 3'b000; end
      3: begin kind = 1'b0; sz = 3'b010; addr = 32'h0; end
      default: ;
    endcase
    return {kind, sz, addr, pay};
  endfunction

  task automatic pushExp(input logic [99:0] f);
    if (!f[99]) begin
      expQ.push_back({2'd2, f[95:64], f[98:96], f[63:32]});
    end else begin
      expQ.push_back({2'd3, bkAddr(f[13:10], f[9:0], 1'b0), 3'b010, f[63:32]});
      expQ.push_back({2'd1, bkAddr(f[13:10], f[9:0], 1'b1), 3'b010, 32'h1});
    end
  endtask

  initial begin
    int          sent = 0;
    int          made = 0;
    bit          acceptedPrev = 0;
    bit          dataPend = 0;
    logic [31:0] pendD = '0;
    logic [1:0]  pendTag = '0;
    bit          stalled = 0;
    logic [31:0] stallAddr = '0;
    logic [68:0] e;
    bit          done = 0;

    void'($urandom(32'd20240611));
    rstN = 1'b0; inValid = 1'b0; inFlit = '0; hReady = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(hTrans == 2'b00, "R1 trans", 32'(hTrans), 32'h0);
    check(inReady == 1'b1, "R1 ready", 32'(inReady), 32'h1);
    @(negedge clk);
    rstN = 1'b1;

    for (int cyc = 0; cyc < CYC_LIMIT && !done; cyc++) begin
      @(negedge clk);
      if (acceptedPrev) inValid = 1'b0;
      hReady = (($urandom % 3) != 0);
      if (!inValid && made < NUM_PKTS && (($urandom % 10) < 6 || made < 4)) begin
        inFlit  = genPkt(made);
        inValid = 1'b1;
        made++;
      end
      #1;
      if (acceptedPrev)
        check(hTrans == 2'b10, "R7 no gap", 32'(hTrans), 32'h2);
      if (stalled)
        check(hTrans == 2'b10 && hAddr == stallAddr, "R5 hold", hAddr, stallAddr);
      if (hTrans != 2'b00)
        check(hTrans == 2'b10 && hWrite, "R9 nonseq", 32'({hTrans, hWrite}), 32'h5);
      if (inReady)
        check(hTrans == 2'b00, "R6 ready bus", 32'(hTrans), 32'h0);
      if (dataPend && hReady) begin
        check(hWdata == pendD, {tagName(pendTag), " data"}, hWdata, pendD);
        dataPend = 0;
      end
      if (!dataPend && expQ.size() == 0)
        check(inReady == 1'b1, "R6 idle ready", 32'(inReady), 32'h1);
      if (hTrans == 2'b10 && hReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R6 extra transfer", hAddr, 32'h0);
        end else begin
          e = expQ.pop_front();
          check(hAddr == e[66:35], {tagName(e[68:67]), " addr"}, hAddr, e[66:35]);
          check(hSize == e[34:32], {tagName(e[68:67]), " size"}, 32'(hSize), 32'(e[34:32]));
          dataPend = 1; pendD = e[31:0]; pendTag = e[68:67];
        end
      end
      stalled = (hTrans == 2'b10 && !hReady);
      if (stalled) stallAddr = hAddr;
      acceptedPrev = inValid && inReady;
      if (acceptedPrev) begin
        check(expQ.size() == 0, "R6 one per sequence", 32'(expQ.size()), 32'h0);
        pushExp(inFlit);
        sent++;
      end
      done = (sent == NUM_PKTS) && (expQ.size() == 0) && !dataPend && !acceptedPrev;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog R6 actual=%0d expected=%0d packets", sent, NUM_PKTS);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule